// File: doc/BRIEF.md
# Dual-Source Ping-Pong Blit Sequencer

This block runs the data flow around a two-input image blending datapath. Source A and source B each own a pair of half-buffers. Each source fills its halves in turn, one DMA burst per half, through a request/acknowledge handshake with external memory. A compute pass starts only when both sources hold a full half and the destination buffer is free. The pass combines the two oldest halves word by word into the destination buffer. The destination buffer is then written back to memory over a third request/acknowledge channel.

The write-back lands in source A's region, at the same addresses that were read for that half. The blend stands in for the real per-pixel arithmetic: it is the floor of the mean of the two source words. A job starts with a one-cycle `start` pulse that carries a length counted in half-buffers. A one-cycle `done` pulse follows the final write-back beat.

Top module: `blit_seq`

## Requirements
- R1: While `rst` is high at a clock edge, all three request outputs, both half-full flags and `done` are low in the following cycle.
- R2: A source raises its request only while at least one of its two halves is empty and fewer than `len_halves` bursts have completed. Every burst is exactly HALF (default 4) acknowledged words. The job fetches exactly `len_halves` bursts per source.
- R3: In the cycle after the acknowledged word that ends a source burst, that source's request is low.
- R4: A source's half-full flag is high from the cycle after a burst fills a half until a pass releases that half. Halves are consumed in the order they were filled, so blended word k always pairs the k-th word fetched from A with the k-th word fetched from B.
- R5: A pass starts only when both half-full flags are high. While one source receives no acknowledges, the destination request never rises.
- R6: After a pass, the destination request stays high until HALF words have been acknowledged. No pass starts while a write-back is in progress.
- R7: Source A word k is read from `a_base + k`, and source B word k from `b_base + k`. Destination word k is written to `a_base + k`, exactly once per job.
- R8: The value written for destination word k is floor((A_k + B_k) / 2) over DW-bit unsigned words.
- R9: `done` is high for exactly one cycle: the cycle after the edge that accepts the final write-back word. After that, every request stays low.
- R10: A `start` with `len_halves` = 0 gives a `done` pulse in the next cycle and raises no request.
- R11: A `start` pulse during a running job is ignored. The job still moves exactly its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Job start pulse, taken only when idle |
| len_halves | input | CNT_W (8) | Job length in half-buffer units |
| a_base | input | AW (16) | Word address of source A region, also the write-back region |
| b_base | input | AW (16) | Word address of source B region |
| a_req | output | 1 | Source A fetch request |
| a_ack | input | 1 | Source A word accepted this cycle |
| a_addr | output | AW (16) | Address of the source A word being fetched |
| a_data | input | DW (8) | Source A word |
| b_req | output | 1 | Source B fetch request |
| b_ack | input | 1 | Source B word accepted this cycle |
| b_addr | output | AW (16) | Address of the source B word being fetched |
| b_data | input | DW (8) | Source B word |
| d_req | output | 1 | Write-back request |
| d_ack | input | 1 | Write-back word accepted this cycle |
| d_addr | output | AW (16) | Write-back word address |
| d_data | output | DW (8) | Write-back word |
| a_half_full | output | 1 | Oldest half of source A is full |
| b_half_full | output | 1 | Oldest half of source B is full |
| done | output | 1 | Job finished pulse |

## Verification
Requests are combinational from registered state. They therefore change one edge after the acknowledge that moves them: the R3 gap after a burst and the R6 hold during a write-back both appear in the cycle after the accepting edge. `done` is registered, so it is due exactly one cycle after the final accepted write-back word, or one cycle after a zero-length start. The bench decides every acknowledge at the falling edge and checks each such one-cycle-later result at the next falling edge. Data and addresses are gathered per write-back beat and compared with the address-derived patterns once the job's `done` has been seen.

// File: rtl/blit_seq_pkg.sv
package blit_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_PASS = 2'd2
  } seq_state_t;
endpackage

// File: rtl/blit_src.sv
module blit_src #(
  parameter int DW      = 8,
  parameter int HALF_LG = 2,
  parameter int CNT_W   = 8,
  parameter int AW      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               enable,
  input  logic [CNT_W-1:0]   total,
  input  logic [AW-1:0]      base,
  input  logic               ack,
  input  logic [DW-1:0]      wdata,
  output logic               req,
  output logic [AW-1:0]      addr,
  input  logic [HALF_LG-1:0] rd_idx,
  output logic [DW-1:0]      rd_data,
  input  logic               release_i,
  output logic               half_full,
  output logic [1:0]         full_pair,
  output logic               burst_end
);
  localparam int HALF = 1 << HALF_LG;

  logic [DW-1:0]      mem [2][HALF];
  logic [1:0]         full, full_nx;
  logic               wr_half, rd_half, gap;
  logic [HALF_LG-1:0] beat;
  logic [CNT_W-1:0]   bursts;
  logic               take;

  assign req       = enable && (bursts != total) && !full[wr_half] && !gap;
  assign take      = req && ack;
  assign burst_end = take && (&beat);
  assign addr      = base + AW'({bursts, beat});
  assign rd_data   = mem[rd_half][rd_idx];
  assign half_full = full[rd_half];
  assign full_pair = full;

  always_comb begin
    full_nx = full;
    if (release_i) full_nx[rd_half] = 1'b0;
    if (burst_end) full_nx[wr_half] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (take) mem[wr_half][beat] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      full    <= '0;
      wr_half <= 1'b0;
      rd_half <= 1'b0;
      gap     <= 1'b0;
      beat    <= '0;
      bursts  <= '0;
    end else begin
      full <= full_nx;
      gap  <= burst_end;
      if (take) beat <= beat + 1'b1;
      if (burst_end) begin
        wr_half <= ~wr_half;
        bursts  <= bursts + 1'b1;
      end
      if (release_i) rd_half <= ~rd_half;
    end
  end
endmodule

// File: rtl/blit_dst.sv
module blit_dst #(
  parameter int DW      = 8,
  parameter int HALF_LG = 2,
  parameter int AW      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [HALF_LG-1:0] wr_idx,
  input  logic [DW-1:0]      wr_data,
  input  logic               go,
  input  logic [AW-1:0]      half_base,
  input  logic               ack,
  output logic               req,
  output logic [AW-1:0]      addr,
  output logic [DW-1:0]      data,
  output logic               last,
  output logic               busy
);
  localparam int HALF = 1 << HALF_LG;

  logic [DW-1:0]      mem [HALF];
  logic [HALF_LG-1:0] idx;
  logic               take;

  assign req  = busy;
  assign take = busy && ack;
  assign last = take && (&idx);
  assign addr = half_base + AW'(idx);
  assign data = mem[idx];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else begin
      if (go) busy <= 1'b1;
      else if (last) busy <= 1'b0;
      if (take) idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/blit_seq.sv
module blit_seq
  import blit_seq_pkg::*;
#(
  parameter int DW      = 8,
  parameter int HALF_LG = 2,
  parameter int CNT_W   = 8,
  parameter int AW      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] len_halves,
  input  logic [AW-1:0]    a_base,
  input  logic [AW-1:0]    b_base,
  output logic             a_req,
  input  logic             a_ack,
  output logic [AW-1:0]    a_addr,
  input  logic [DW-1:0]    a_data,
  output logic             b_req,
  input  logic             b_ack,
  output logic [AW-1:0]    b_addr,
  input  logic [DW-1:0]    b_data,
  output logic             d_req,
  input  logic             d_ack,
  output logic [AW-1:0]    d_addr,
  output logic [DW-1:0]    d_data,
  output logic             a_half_full,
  output logic             b_half_full,
  output logic             done
);
  function automatic logic [DW-1:0] blend_px(input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic [DW:0] sum;
    sum = {1'b0, x} + {1'b0, y};
    return sum[DW:1];
  endfunction

  seq_state_t         state;
  logic [CNT_W-1:0]   len_q, drained;
  logic [AW-1:0]      a_base_q, b_base_q;
  logic [HALF_LG-1:0] pidx;

  logic job_start, zero_job, pass_start, pass_end, final_drain, src_en;
  logic [DW-1:0] a_rd, b_rd;
  logic [1:0] a_full_pair, b_full_pair;
  logic a_burst_end, b_burst_end, d_last, d_busy;
  logic [AW-1:0] half_base;

  assign job_start   = (state == ST_IDLE) && start && (len_halves != '0);
  assign zero_job    = (state == ST_IDLE) && start && (len_halves == '0);
  assign pass_start  = (state == ST_RUN) && a_half_full && b_half_full && !d_busy;
  assign pass_end    = (state == ST_PASS) && (&pidx);
  assign final_drain = d_last && (drained == len_q - 1'b1);
  assign src_en      = (state != ST_IDLE);
  assign half_base   = a_base_q + AW'({drained, {HALF_LG{1'b0}}});

  blit_src #(.DW(DW), .HALF_LG(HALF_LG), .CNT_W(CNT_W), .AW(AW)) u_src_a (
    .clk(clk), .rst(rst), .clear(job_start), .enable(src_en), .total(len_q),
    .base(a_base_q), .ack(a_ack), .wdata(a_data), .req(a_req), .addr(a_addr),
    .rd_idx(pidx), .rd_data(a_rd), .release_i(pass_end), .half_full(a_half_full),
    .full_pair(a_full_pair), .burst_end(a_burst_end)
  );

  blit_src #(.DW(DW), .HALF_LG(HALF_LG), .CNT_W(CNT_W), .AW(AW)) u_src_b (
    .clk(clk), .rst(rst), .clear(job_start), .enable(src_en), .total(len_q),
    .base(b_base_q), .ack(b_ack), .wdata(b_data), .req(b_req), .addr(b_addr),
    .rd_idx(pidx), .rd_data(b_rd), .release_i(pass_end), .half_full(b_half_full),
    .full_pair(b_full_pair), .burst_end(b_burst_end)
  );

  blit_dst #(.DW(DW), .HALF_LG(HALF_LG), .AW(AW)) u_dst (
    .clk(clk), .rst(rst), .wr_en(state == ST_PASS), .wr_idx(pidx),
    .wr_data(blend_px(a_rd, b_rd)), .go(pass_end), .half_base(half_base),
    .ack(d_ack), .req(d_req), .addr(d_addr), .data(d_data), .last(d_last),
    .busy(d_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      len_q    <= '0;
      a_base_q <= '0;
      b_base_q <= '0;
      drained  <= '0;
      pidx     <= '0;
      done     <= 1'b0;
    end else begin
      done <= final_drain || zero_job;
      if (job_start) begin
        len_q    <= len_halves;
        a_base_q <= a_base;
        b_base_q <= b_base;
        drained  <= '0;
      end else if (d_last) begin
        drained <= drained + 1'b1;
      end
      if (pass_start) pidx <= '0;
      else if (state == ST_PASS) pidx <= pidx + 1'b1;
      case (state)
        ST_IDLE: if (job_start) state <= ST_RUN;
        ST_RUN: begin
          if (final_drain) state <= ST_IDLE;
          else if (pass_start) state <= ST_PASS;
        end
        ST_PASS: if (pass_end) state <= ST_RUN;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blit_seq_chk.sv
module blit_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       a_req,
  input logic       b_req,
  input logic       d_req,
  input logic       d_ack,
  input logic       done,
  input logic       a_half_full,
  input logic       b_half_full,
  input logic [1:0] a_full_pair,
  input logic [1:0] b_full_pair,
  input logic       a_burst_end,
  input logic       b_burst_end,
  input logic       pass_start,
  input logic       d_busy
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!a_req && !b_req && !d_req && !done && !a_half_full && !b_half_full));

  a_r2_a_room: assert property (@(posedge clk) disable iff (rst)
    a_req |-> !(&a_full_pair));

  a_r2_b_room: assert property (@(posedge clk) disable iff (rst)
    b_req |-> !(&b_full_pair));

  a_r3_a_gap: assert property (@(posedge clk) disable iff (rst)
    a_burst_end |=> !a_req);

  a_r3_b_gap: assert property (@(posedge clk) disable iff (rst)
    b_burst_end |=> !b_req);

  a_r5_both_ready: assert property (@(posedge clk) disable iff (rst)
    pass_start |-> (a_half_full && b_half_full));

  a_r6_drain_first: assert property (@(posedge clk) disable iff (rst)
    pass_start |-> !d_busy);

  a_r6_drain_holds: assert property (@(posedge clk) disable iff (rst)
    (d_req && !d_ack) |=> d_req);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind blit_seq blit_seq_chk u_chk (
  .clk(clk), .rst(rst), .a_req(a_req), .b_req(b_req), .d_req(d_req),
  .d_ack(d_ack), .done(done), .a_half_full(a_half_full), .b_half_full(b_half_full),
  .a_full_pair(a_full_pair), .b_full_pair(b_full_pair),
  .a_burst_end(a_burst_end), .b_burst_end(b_burst_end),
  .pass_start(pass_start), .d_busy(d_busy)
);

// File: tb/tb_blit_seq.sv
module tb_blit_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam logic [15:0] ABASE = 16'h0100;
  localparam logic [15:0] BBASE = 16'h0800;

  logic clk = 1'b0;
  logic rst, start;
  logic [7:0] len_halves;
  logic [15:0] a_base, b_base;
  logic a_req, a_ack, b_req, b_ack, d_req, d_ack;
  logic [15:0] a_addr, b_addr, d_addr;
  logic [7:0] a_data, b_data, d_data;
  logic a_half_full, b_half_full, done;

  int errors = 0, checks = 0;
  int a_acks = 0, b_acks = 0, d_writes = 0, done_cnt = 0, exp_total = 0;
  bit a_en = 0, b_en = 0, d_en = 0, stall = 0;
  bit a_end_flag = 0, b_end_flag = 0, d_final_flag = 0;
  int wr_cnt [64];
  logic [7:0] wr_val [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  blit_seq dut (
    .clk(clk), .rst(rst), .start(start), .len_halves(len_halves),
    .a_base(a_base), .b_base(b_base),
    .a_req(a_req), .a_ack(a_ack), .a_addr(a_addr), .a_data(a_data),
    .b_req(b_req), .b_ack(b_ack), .b_addr(b_addr), .b_data(b_data),
    .d_req(d_req), .d_ack(d_ack), .d_addr(d_addr), .d_data(d_data),
    .a_half_full(a_half_full), .b_half_full(b_half_full), .done(done)
  );

  function automatic logic [7:0] pat_a(input logic [15:0] x);
    return 8'(x * 16'd7 + 16'd3);
  endfunction
  function automatic logic [7:0] pat_b(input logic [15:0] x);
    return 8'(x * 16'd13 + 16'd5) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] mean_ref(input int k);
    int s;
    s = int'(pat_a(ABASE + 16'(k))) + int'(pat_b(BBASE + 16'(k)));
    return 8'(s / 2);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit let_through(input int ph);
    return !stall || (ph % 3) != 1;
  endfunction

  initial begin : resp_a
    int ph = 0;
    a_ack = 0; a_data = '0;
    forever begin
      @(negedge clk);
      ph++;
      if (a_end_flag) begin
        check(a_req == 1'b0, "R3 source A request after burst", int'(a_req), 0);
        a_end_flag = 0;
      end
      a_ack = 0;
      if (a_req && a_en && let_through(ph)) begin
        a_ack = 1;
        a_data = pat_a(a_addr);
        check(a_addr == ABASE + 16'(a_acks), "R7 source A address", a_addr, ABASE + a_acks);
        a_acks++;
        if (a_acks % HALF == 0) a_end_flag = 1;
      end
    end
  end

  initial begin : resp_b
    int ph = 0;
    b_ack = 0; b_data = '0;
    forever begin
      @(negedge clk);
      ph++;
      if (b_end_flag) begin
        check(b_req == 1'b0, "R3 source B request after burst", int'(b_req), 0);
        b_end_flag = 0;
      end
      b_ack = 0;
      if (b_req && b_en && let_through(ph + 1)) begin
        b_ack = 1;
        b_data = pat_b(b_addr);
        check(b_addr == BBASE + 16'(b_acks), "R7 source B address", b_addr, BBASE + b_acks);
        b_acks++;
        if (b_acks % HALF == 0) b_end_flag = 1;
      end
    end
  end

  initial begin : resp_d
    int ph = 0;
    d_ack = 0;
    forever begin
      @(negedge clk);
      ph++;
      if (done) done_cnt++;
      if (d_final_flag) begin
        check(done == 1'b1, "R9 done after final write-back", int'(done), 1);
        d_final_flag = 0;
      end
      if (d_writes % HALF != 0)
        check(d_req == 1'b1, "R6 write-back held mid-half", int'(d_req), 1);
      d_ack = 0;
      if (d_req && d_en && let_through(ph + 2)) begin
        int off;
        d_ack = 1;
        off = int'(d_addr) - int'(ABASE);
        if (off < 0 || off > 63) check(0, "R7 write-back address range", off, 0);
        else begin
          wr_cnt[off]++;
          wr_val[off] = d_data;
        end
        d_writes++;
        if (d_writes == exp_total) d_final_flag = 1;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog: actual=%0d expected=%0d", done_cnt, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic clear_stats(input int len);
    a_acks = 0; b_acks = 0; d_writes = 0; done_cnt = 0;
    exp_total = len * HALF;
    for (int i = 0; i < 64; i++) begin wr_cnt[i] = 0; wr_val[i] = '0; end
  endtask

  task automatic kick(input int len);
    @(negedge clk);
    start = 1; len_halves = 8'(len);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && done_cnt == 0; i++) @(negedge clk);
    check(done_cnt == 1, "R9 done count", done_cnt, 1);
  endtask

  task automatic check_results(input int len);
    check(a_acks == len * HALF, "R2 source A words", a_acks, len * HALF);
    check(b_acks == len * HALF, "R2 source B words", b_acks, len * HALF);
    check(d_writes == len * HALF, "R7 write-back words", d_writes, len * HALF);
    for (int k = 0; k < len * HALF; k++) begin
      check(wr_cnt[k] == 1, "R7 write-back once per address", wr_cnt[k], 1);
      check(wr_val[k] == mean_ref(k), "R8 R4 blended value", wr_val[k], mean_ref(k));
    end
    repeat (3) @(negedge clk);
    check(!a_req && !b_req && !d_req, "R9 idle after done",
          {a_req, b_req, d_req}, 0);
  endtask

  task automatic t_reset();
    check(!a_req && !b_req && !d_req, "R1 requests in reset", {a_req, b_req, d_req}, 0);
    check(!a_half_full && !b_half_full, "R1 flags in reset", {a_half_full, b_half_full}, 0);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
  endtask

  task automatic t_basic();
    clear_stats(3);
    a_en = 1; b_en = 1; d_en = 1; stall = 0;
    kick(3);
    wait_done();
    check_results(3);
  endtask

  task automatic t_starve();
    clear_stats(2);
    a_en = 1; b_en = 0; d_en = 1; stall = 0;
    kick(2);
    repeat (40) @(negedge clk);
    check(a_acks == 2 * HALF, "R2 fill stops when both halves full", a_acks, 2 * HALF);
    check(a_req == 1'b0, "R2 no request without room", int'(a_req), 0);
    check(a_half_full == 1'b1, "R4 source A flag held", int'(a_half_full), 1);
    check(b_half_full == 1'b0, "R4 source B flag empty", int'(b_half_full), 0);
    check(d_writes == 0, "R5 no pass with one source empty", d_writes, 0);
    b_en = 1;
    wait_done();
    check_results(2);
  endtask

  task automatic t_stall_restart();
    clear_stats(4);
    a_en = 1; b_en = 1; d_en = 1; stall = 1;
    kick(4);
    repeat (10) @(negedge clk);
    kick(2);
    wait_done();
    check_results(4);
    repeat (20) @(negedge clk);
    check(done_cnt == 1, "R11 restart ignored, single done", done_cnt, 1);
    check(a_acks == 4 * HALF, "R11 restart ignored, length kept", a_acks, 4 * HALF);
  endtask

  task automatic t_zero();
    clear_stats(0);
    a_en = 1; b_en = 1; d_en = 1; stall = 0;
    kick(0);
    check(done == 1'b1, "R10 done after zero length", int'(done), 1);
    @(negedge clk);
    check(done == 1'b0, "R10 done one cycle", int'(done), 0);
    check(!a_req && !b_req && !d_req, "R10 no requests",
          {a_req, b_req, d_req}, 0);
    check(a_acks + b_acks + d_writes == 0, "R10 no transfers", a_acks + b_acks + d_writes, 0);
  endtask

  initial begin
    rst = 1; start = 0; len_halves = '0; a_base = ABASE; b_base = BBASE;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_basic();
    t_starve();
    t_stall_restart();
    t_zero();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule